// File: doc/BRIEF.md
# Ring Detect Status and Interrupt Logic

This block turns two raw comparator flags into ring information for a line interface. One flag means the line voltage is above the positive ring threshold. The other means it is below the negative ring threshold. Both flags are synchronised into the clock domain. A mode bit then decides whether only positive excursions count as ring (half-wave) or both polarities do (full-wave).

From the detected ring the block produces four things:
- a ring indicator pin with selectable polarity;
- three status flags: a positive flag, a negative flag and a retriggerable ring-active flag;
- an interrupt with a mask bit, a pulse-edge option and write-one-to-clear;
- a stream of signed 16-bit ring samples for the transmit data path.

Control is one write strobe with a five-bit data word. Bits 0 to 3 are stored as configuration. Bit 4 is a clear command and is not stored. The sample stream uses valid/ready. Once `smp_valid_o` is high, the valid flag and `smp_data_o` stay frozen until a cycle where `smp_ready_i` is high, which completes the transfer. The output register then reloads in that same cycle. A consumer may hold `smp_ready_i` low for as long as it likes, and no sample is lost or changed while it waits.

Top module: `ring_detect_top`

## Requirements
- R1: Each comparator input passes through a two-flop synchroniser. `stat_pos_o` and `stat_neg_o` follow their comparator two clocks after it changes, and both are 0 while neither comparator is active.
- R2: With configuration bit 0 (full-wave) clear, only the positive comparator counts as ring. With it set, either comparator counts.
- R3: `ring_ind_o` is low during ring and high otherwise while configuration bit 1 is 0 (the reset value). With bit 1 set, it is high during ring.
- R4: Each new start of ring loads a one-shot with HOLD_TICKS. `stat_active_o` stays high while the count is nonzero, so a single ring start gives exactly HOLD_TICKS active cycles. A new ring start before expiry reloads the count.
- R5: While `off_hook_i` is high, the one-shot is forced to zero on the next edge. This takes priority over a reload.
- R6: With configuration bit 2 (mask) set, a rising `stat_active_o` sets `irq_o`. With mask clear and bit 3 clear, `irq_o` never sets.
- R7: A write with data bit 4 set clears `irq_o`. A set condition in the same cycle wins over the clear.
- R8: With configuration bit 3 set, both the start and the end of every ring pulse set `irq_o`.
- R9: New samples are valid only while `link_up_i` is 1, `off_hook_i` is 0 and `monitor_i` is 0.
- R10: The sample value is 16'h7FFF during ring. Outside ring it is 16'h8000 in half-wave mode and IDLE_CODE (default 16'h04CC) in full-wave mode.
- R11: While `smp_valid_o` is high and `smp_ready_i` is low, `smp_valid_o` stays high and `smp_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_pos_i | input | 1 | Asynchronous flag: above positive threshold |
| cmp_neg_i | input | 1 | Asynchronous flag: below negative threshold |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 5 | Bit0 full-wave, bit1 indicator active-high, bit2 mask, bit3 pulse-edge IRQ, bit4 clear IRQ |
| off_hook_i | input | 1 | Line off-hook |
| link_up_i | input | 1 | Serial link powered up |
| monitor_i | input | 1 | On-hook line monitor mode |
| ring_ind_o | output | 1 | Ring indicator, polarity per bit 1 |
| stat_pos_o | output | 1 | Positive excursion status |
| stat_neg_o | output | 1 | Negative excursion status |
| stat_active_o | output | 1 | Retriggerable ring-active flag |
| irq_o | output | 1 | Interrupt request |
| smp_valid_o | output | 1 | Sample valid |
| smp_ready_i | input | 1 | Sample ready from consumer |
| smp_data_o | output | 16 | Signed ring sample |

## Verification
The interrupt set path and the software clear can land on the same clock edge. The bench provokes this with the pulse-edge option on. It releases the positive comparator, counts the two synchroniser edges, and places a one-cycle clear write exactly over the edge where the end of the ring pulse is recognised. The check passes if `irq_o` is still high afterwards, because a set must win over a clear. A separate check confirms that a clear written outside any set event does drop `irq_o`.

// File: rtl/rd_pkg.sv
package rd_pkg;
  localparam int CTL_W     = 5;
  localparam int B_FULL    = 0;
  localparam int B_POL     = 1;
  localparam int B_MASK    = 2;
  localparam int B_EDGE    = 3;
  localparam int B_CLR     = 4;
  localparam int SMP_W     = 16;
  localparam logic [SMP_W-1:0] SMP_RING = 16'h7FFF;
  localparam logic [SMP_W-1:0] SMP_HALF_IDLE = 16'h8000;

  typedef struct packed {
    logic edge_irq;
    logic mask;
    logic pol_high;
    logic full;
  } rd_cfg_t;
endpackage

// File: rtl/rd_sync.sv
module rd_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/rd_oneshot.sv
module rd_oneshot #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_i,
  input  logic off_hook_i,
  output logic active_o
);
  localparam int CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] RELOAD = CW'(HOLD);

  logic [CW-1:0] cnt;
  logic          det_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      det_q <= 1'b0;
    end else begin
      det_q <= det_i;
      if (off_hook_i)
        cnt <= '0;
      else if (det_i && !det_q)
        cnt <= RELOAD;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  assign active_o = (cnt != '0);
endmodule

// File: rtl/rd_irq.sv
module rd_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic det_i,
  input  logic active_i,
  input  logic mask_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic irq_o
);
  logic det_q, act_q, set_ev;

  assign set_ev = (mask_i && active_i && !act_q) || (edge_i && (det_i != det_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= 1'b0;
      act_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      det_q <= det_i;
      act_q <= active_i;
      if (set_ev)
        irq_o <= 1'b1;
      else if (clr_i)
        irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rd_sample.sv
module rd_sample
  import rd_pkg::*;
#(
  parameter logic [SMP_W-1:0] IDLE_CODE = 16'h04CC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_i,
  input  logic             full_i,
  input  logic             elig_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [SMP_W-1:0] data_o
);
  logic [SMP_W-1:0] value;

  always_comb begin
    if (det_i)       value = SMP_RING;
    else if (full_i) value = IDLE_CODE;
    else             value = SMP_HALF_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= SMP_HALF_IDLE;
    end else if (!valid_o || ready_i) begin
      valid_o <= elig_i;
      data_o  <= value;
    end
  end
endmodule

// File: rtl/ring_detect_top.sv
module ring_detect_top
  import rd_pkg::*;
#(
  parameter int              HOLD_TICKS = 250_000_000,
  parameter logic [15:0]     IDLE_CODE  = 16'h04CC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_pos_i,
  input  logic             cmp_neg_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             off_hook_i,
  input  logic             link_up_i,
  input  logic             monitor_i,
  output logic             ring_ind_o,
  output logic             stat_pos_o,
  output logic             stat_neg_o,
  output logic             stat_active_o,
  output logic             irq_o,
  output logic             smp_valid_o,
  input  logic             smp_ready_i,
  output logic [15:0]      smp_data_o
);
  rd_cfg_t    cfg;
  logic [1:0] cmp_s;
  logic       ring_det;
  logic       clr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg <= '0;
    else if (ctl_wr_i) begin
      cfg.full     <= ctl_wdata_i[B_FULL];
      cfg.pol_high <= ctl_wdata_i[B_POL];
      cfg.mask     <= ctl_wdata_i[B_MASK];
      cfg.edge_irq <= ctl_wdata_i[B_EDGE];
    end
  end

  assign clr_req = ctl_wr_i && ctl_wdata_i[B_CLR];

  rd_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({cmp_neg_i, cmp_pos_i}),
    .q_o(cmp_s)
  );

  assign stat_pos_o = cmp_s[0];
  assign stat_neg_o = cmp_s[1];
  assign ring_det   = cmp_s[0] || (cfg.full && cmp_s[1]);
  assign ring_ind_o = cfg.pol_high ? ring_det : !ring_det;

  rd_oneshot #(.HOLD(HOLD_TICKS)) u_oneshot (
    .clk(clk), .rst_n(rst_n),
    .det_i(ring_det),
    .off_hook_i(off_hook_i),
    .active_o(stat_active_o)
  );

  rd_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .det_i(ring_det),
    .active_i(stat_active_o),
    .mask_i(cfg.mask),
    .edge_i(cfg.edge_irq),
    .clr_i(clr_req),
    .irq_o(irq_o)
  );

  rd_sample #(.IDLE_CODE(IDLE_CODE)) u_sample (
    .clk(clk), .rst_n(rst_n),
    .det_i(ring_det),
    .full_i(cfg.full),
    .elig_i(link_up_i && !off_hook_i && !monitor_i),
    .ready_i(smp_ready_i),
    .valid_o(smp_valid_o),
    .data_o(smp_data_o)
  );
endmodule

// File: rtl/rd_checker.sv
module rd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_full,
  input logic        cfg_pol,
  input logic        cfg_mask,
  input logic        cfg_edge,
  input logic        off_hook_i,
  input logic        stat_pos_o,
  input logic        stat_neg_o,
  input logic        stat_active_o,
  input logic        ring_ind_o,
  input logic        irq_o,
  input logic        smp_valid_o,
  input logic        smp_ready_i,
  input logic [15:0] smp_data_o
);
  AST_HALF_NEG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_full && stat_neg_o && !stat_pos_o) |-> (ring_ind_o == !cfg_pol)); // R2

  AST_OFFHOOK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    off_hook_i |=> !stat_active_o); // R5

  AST_ACTIVE_NEEDS_RING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_active_o) |-> $past(stat_pos_o || (cfg_full && stat_neg_o))); // R4

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_mask && !cfg_edge && !irq_o) |=> !irq_o); // R6

  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_data_o))); // R11
endmodule

bind ring_detect_top rd_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_full(cfg.full), .cfg_pol(cfg.pol_high),
  .cfg_mask(cfg.mask), .cfg_edge(cfg.edge_irq),
  .off_hook_i(off_hook_i),
  .stat_pos_o(stat_pos_o), .stat_neg_o(stat_neg_o),
  .stat_active_o(stat_active_o), .ring_ind_o(ring_ind_o),
  .irq_o(irq_o), .smp_valid_o(smp_valid_o),
  .smp_ready_i(smp_ready_i), .smp_data_o(smp_data_o)
);

// File: tb/tb_ring_detect_top.sv
module tb_ring_detect_top;
  localparam int HOLD = 16;
  localparam logic [15:0] IDLE = 16'h04CC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_pos = 1'b0, cmp_neg = 1'b0;
  logic ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0;
  logic off_hook = 1'b0, link_up = 1'b0, monitor = 1'b0;
  logic ring_ind, st_pos, st_neg, st_act, irq, s_valid;
  logic s_ready = 1'b1;
  logic [15:0] s_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ring_detect_top #(.HOLD_TICKS(HOLD), .IDLE_CODE(IDLE)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmp_pos_i(cmp_pos), .cmp_neg_i(cmp_neg),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
    .off_hook_i(off_hook), .link_up_i(link_up), .monitor_i(monitor),
    .ring_ind_o(ring_ind), .stat_pos_o(st_pos), .stat_neg_o(st_neg),
    .stat_active_o(st_act), .irq_o(irq),
    .smp_valid_o(s_valid), .smp_ready_i(s_ready), .smp_data_o(s_data)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_active(input int n, inout int c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (st_act) c++;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c;
    logic [15:0] held;
    idle(3);
    // reset state
    check(ring_ind == 1'b1 && irq == 1'b0 && st_act == 1'b0 && s_valid == 1'b0,
          "R3 reset idle", {ring_ind, irq, st_act, s_valid}, 4'b1000);
    rst_n = 1'b1;
    link_up = 1'b1;
    idle(2);

    // exhaustive sweep of mode, polarity and comparators
    for (int cf = 0; cf < 4; cf++) begin
      wr(5'(cf));
      for (int pn = 0; pn < 4; pn++) begin
        bit fw, ph, p, n, det;
        logic [15:0] es;
        fw = cf[0]; ph = cf[1]; p = pn[0]; n = pn[1];
        @(negedge clk); cmp_pos = p; cmp_neg = n;
        idle(4);
        det = p || (fw && n);
        es = det ? 16'h7FFF : (fw ? IDLE : 16'h8000);
        check(st_pos == p && st_neg == n, "R1 status follows comparators",
              {st_pos, st_neg}, {p, n});
        check(ring_ind == (ph ? det : !det), "R2 R3 indicator mode/polarity",
              ring_ind, ph ? det : !det);
        check(s_data == es, "R10 sample value", s_data, es);
      end
      @(negedge clk); cmp_pos = 1'b0; cmp_neg = 1'b0;
    end
    wr(5'b10000);
    idle(HOLD + 4);

    // single ring start: exact hold length
    c = 0;
    @(negedge clk); cmp_pos = 1'b1;
    count_active(3, c);
    cmp_pos = 1'b0;
    count_active(40, c);
    check(c == HOLD, "R4 one-shot length", c, HOLD);

    // retrigger 11 cycles after first start
    c = 0;
    @(negedge clk); cmp_pos = 1'b1;
    count_active(3, c);
    cmp_pos = 1'b0;
    count_active(8, c);
    cmp_pos = 1'b1;
    count_active(3, c);
    cmp_pos = 1'b0;
    count_active(40, c);
    check(c == HOLD + 11, "R4 retrigger reload", c, HOLD + 11);

    // off-hook forces ring-active low
    @(negedge clk); cmp_pos = 1'b1;
    idle(4);
    check(st_act == 1'b1, "R4 active during ring", st_act, 1);
    off_hook = 1'b1;
    @(negedge clk);
    check(st_act == 1'b0, "R5 off-hook clears", st_act, 0);
    cmp_pos = 1'b0;
    idle(3);
    cmp_pos = 1'b1;
    idle(4);
    check(st_act == 1'b0, "R5 off-hook blocks reload", st_act, 0);
    cmp_pos = 1'b0; off_hook = 1'b0;
    idle(4);

    // masked interrupt on rising ring-active
    wr(5'b10100);
    check(irq == 1'b0, "R7 cleared before mask test", irq, 0);
    @(negedge clk); cmp_pos = 1'b1;
    idle(3);
    cmp_pos = 1'b0;
    idle(3);
    check(irq == 1'b1, "R6 mask raises irq", irq, 1);
    wr(5'b10100);
    check(irq == 1'b0, "R7 clear drops irq", irq, 0);
    idle(HOLD + 4);
    check(irq == 1'b0, "R6 no irq on expiry", irq, 0);

    // mask off: no interrupt
    wr(5'b10000);
    @(negedge clk); cmp_pos = 1'b1;
    idle(3);
    cmp_pos = 1'b0;
    idle(HOLD + 6);
    check(irq == 1'b0, "R6 unmasked stays quiet", irq, 0);

    // pulse-edge option: start and end, with coincident clear
    wr(5'b11000);
    @(negedge clk); cmp_pos = 1'b1;
    idle(5);
    check(irq == 1'b1, "R8 irq at ring start", irq, 1);
    wr(5'b11000);
    check(irq == 1'b0, "R7 clear after start", irq, 0);
    cmp_pos = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 5'b11000;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
    check(irq == 1'b1, "R7 R8 set wins over clear at ring end", irq, 1);
    wr(5'b10000);
    check(irq == 1'b0, "R7 final clear", irq, 0);
    idle(HOLD + 4);

    // eligibility sweep with ready high
    for (int e = 0; e < 8; e++) begin
      bit lu, oh, mo;
      lu = e[0]; oh = e[1]; mo = e[2];
      @(negedge clk); link_up = lu; off_hook = oh; monitor = mo;
      idle(3);
      check(s_valid == (lu && !oh && !mo), "R9 sample eligibility", s_valid, lu && !oh && !mo);
    end
    @(negedge clk); link_up = 1'b1; off_hook = 1'b0; monitor = 1'b0;
    idle(4);

    // back-pressure: data frozen while not ready
    s_ready = 1'b0;
    idle(2);
    held = s_data;
    check(held == 16'h8000, "R10 half-wave idle code", held, 16'h8000);
    cmp_pos = 1'b1;
    idle(5);
    check(s_valid == 1'b1 && s_data == held, "R11 stall holds sample", s_data, held);
    s_ready = 1'b1;
    idle(2);
    check(s_data == 16'h7FFF, "R11 R10 resumes with ring code", s_data, 16'h7FFF);
    cmp_pos = 1'b0;
    idle(4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule